// File: doc/BRIEF.md
# Indexed Display Controller Register Port

This block is the host-facing register front end of a simple display controller. The host sees only two 32-bit locations on an I/O bus: an index port and a value port. It first writes a register number to the index port. A following read or write on the value port then moves data to or from that internal register. Behind this pair sit the following registers:

- a version ID with a negotiation handshake
- a capability word
- the mode geometry (width, height, bits per pixel) and a derived line pitch
- the controller enable
- a config-done flag that gates command fetch
- a sync request and a busy flag that tracks draining of the command engine

Some register writes are filtered. A version write settles on a supported ID. A bits-per-pixel write is accepted only when the 8-bit-emulation capability is present, and then only for two legal depths. Geometry writes beyond the parameterised maxima are dropped. Every change to width or bits per pixel recomputes the line pitch. A sync write emits a one-cycle drain request to the command engine. Busy then stays high until the engine reports that it is idle.

Top module: `dispctl_regport`

## Requirements
- R1: Bus select 0 is the index port and select 1 the value port. A write to select 0 stores the full 32-bit index. A read strobe returns data on io_rdata one clock later, with io_rvalid high for that one cycle. Reading select 0 returns the stored index.
- R2: The version register is at index 0. It supports IDs from ID_BASE to ID_BASE+ID_COUNT-1, and the top ID is its reset value. Writing a supported ID reads back unchanged. A write above the range reads back as the top ID, and a write below it reads back as ID_BASE.
- R3: When bit EMU_BIT of the capability word is clear, bits-per-pixel (index 6) ignores all writes and holds HOST_BPP.
- R4: When bit EMU_BIT is set, a write of 8 or HOST_BPP to bits-per-pixel is stored. Any other value is ignored. The reset value is HOST_BPP.
- R5: Bit 0 of a write to enable (index 1) sets disp_on from the next clock. A value of 0 returns the display to the legacy mode.
- R6: Bit 0 of a write to config-done (index 10) drives fetch_en from the next clock. Writing 0 stops command fetch.
- R7: Any write to sync (index 11) gives a one-cycle drain_req. Busy (index 12, and port busy) goes to 1 on the same clock. It returns to 0 on the first later clock at which eng_idle is high.
- R8: Line pitch (index 8) is ceil(width*bpp/32)*4 bytes. It is recomputed one clock after any width or bits-per-pixel change.
- R9: Width (index 2) and height (index 3) store the written value only if it does not exceed MAX_W and MAX_H (read at indexes 4 and 5). Larger writes are ignored.
- R10: Indexes 4, 5, 7 (HOST_BPP), 8, 9 (capabilities) and 12 are read-only, and writes to them change nothing. Any index above 12 reads as 0, and a write to it changes no register.
- R11: After reset the outputs and registers hold these values: disp_on, fetch_en, busy and drain_req are 0, width is RST_W, height is RST_H, bpp is HOST_BPP, and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Bus write strobe |
| io_rd | input | 1 | Bus read strobe |
| io_sel | input | 1 | 0 = index port, 1 = value port |
| io_wdata | input | 32 | Bus write data |
| io_rdata | output | 32 | Registered read data |
| io_rvalid | output | 1 | Read data valid, one cycle after io_rd |
| eng_idle | input | 1 | Command engine has no queued work |
| disp_on | output | 1 | Controller enabled |
| fetch_en | output | 1 | Command fetch permitted |
| drain_req | output | 1 | One-cycle drain request to the engine |
| busy | output | 1 | Drain in progress |
| mode_width | output | $clog2(MAX_W+1) | Current width |
| mode_height | output | $clog2(MAX_H+1) | Current height |
| mode_bpp | output | 6 | Current bits per pixel |
| line_pitch | output | $clog2(MAX_W+1)+4 | Current bytes per line |

## Verification
The bench builds two copies of the block on one shared bus. The main copy has HOST_BPP=24 with the emulation bit set, MAX_W=1280 and MAX_H=1024. A 24-bit depth makes the round-up to four bytes visible in the pitch for most widths, and the smaller maxima let random width and height writes land on both sides of the limit. The second copy has a capability word of zero, so the same bits-per-pixel writes reach the read-only path. An ID_COUNT of 3 lets the version handshake fall through both clamps and the supported window.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
  localparam logic SEL_INDEX = 1'b0;
  localparam logic SEL_VALUE = 1'b1;

  localparam logic [31:0] IX_ID       = 32'd0;
  localparam logic [31:0] IX_ENABLE   = 32'd1;
  localparam logic [31:0] IX_WIDTH    = 32'd2;
  localparam logic [31:0] IX_HEIGHT   = 32'd3;
  localparam logic [31:0] IX_MAX_W    = 32'd4;
  localparam logic [31:0] IX_MAX_H    = 32'd5;
  localparam logic [31:0] IX_BPP      = 32'd6;
  localparam logic [31:0] IX_HOST_BPP = 32'd7;
  localparam logic [31:0] IX_PITCH    = 32'd8;
  localparam logic [31:0] IX_CAPS     = 32'd9;
  localparam logic [31:0] IX_CFG_DONE = 32'd10;
  localparam logic [31:0] IX_SYNC     = 32'd11;
  localparam logic [31:0] IX_BUSY     = 32'd12;

  localparam int BPP_W = 6;
endpackage

// File: rtl/dispctl_version.sv
module dispctl_version #(
  parameter logic [31:0] ID_BASE  = 32'h5A00_0000,
  parameter int          ID_COUNT = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_val,
  output logic [31:0] id_q
);
  localparam logic [31:0] ID_TOP = ID_BASE + 32'(ID_COUNT) - 32'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q <= ID_TOP;
    end else if (wr_en) begin
      if (wr_val > ID_TOP)       id_q <= ID_TOP;
      else if (wr_val < ID_BASE) id_q <= ID_BASE;
      else                       id_q <= wr_val;
    end
  end

  p_id_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    (id_q >= ID_BASE) && (id_q <= ID_TOP));

  p_id_echo_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_val >= ID_BASE && wr_val <= ID_TOP) |=> (id_q == $past(wr_val)));
endmodule

// File: rtl/dispctl_mode.sv
module dispctl_mode #(
  parameter int MAX_W    = 2048,
  parameter int MAX_H    = 1536,
  parameter int RST_W    = 640,
  parameter int RST_H    = 480,
  parameter int HOST_BPP = 32,
  parameter bit EMU_ON   = 1'b1,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1),
  localparam int BW = dispctl_pkg::BPP_W,
  localparam int PW = WW + 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_w,
  input  logic          wr_h,
  input  logic          wr_b,
  input  logic [31:0]   wr_val,
  output logic [WW-1:0] w_q,
  output logic [HW-1:0] h_q,
  output logic [BW-1:0] b_q,
  output logic [PW-1:0] pitch_q
);
  logic [WW+BW-1:0] prod;
  logic [WW+BW:0]   bits_sum;
  logic [PW-1:0]    pitch_n;
  logic             bpp_ok;

  assign bpp_ok   = EMU_ON && ((wr_val == 32'd8) || (wr_val == 32'(HOST_BPP)));
  assign prod     = {{BW{1'b0}}, w_q} * {{WW{1'b0}}, b_q};
  assign bits_sum = {1'b0, prod} + (WW+BW+1)'(31);
  assign pitch_n  = {bits_sum[WW+BW:5], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q <= WW'(RST_W);
      h_q <= HW'(RST_H);
      b_q <= BW'(HOST_BPP);
    end else begin
      if (wr_w && wr_val <= 32'(MAX_W)) w_q <= wr_val[WW-1:0];
      if (wr_h && wr_val <= 32'(MAX_H)) h_q <= wr_val[HW-1:0];
      if (wr_b && bpp_ok)               b_q <= wr_val[BW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pitch_q <= PW'(((RST_W * HOST_BPP + 31) / 32) * 4);
    else     pitch_q <= pitch_n;
  end

  p_bpp_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (b_q == BW'(8)) || (b_q == BW'(HOST_BPP)));

  p_bpp_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    !EMU_ON |-> (b_q == BW'(HOST_BPP)));

  p_geom_max_r9: assert property (@(posedge clk) disable iff (rst)
    (32'(w_q) <= 32'(MAX_W)) && (32'(h_q) <= 32'(MAX_H)));

  p_pitch_bound_r8: assert property (@(posedge clk) disable iff (rst)
    ($stable(w_q) && $stable(b_q)) |->
      (({pitch_q, 3'b000} >= {1'b0, prod}) && ({pitch_q, 3'b000} < {1'b0, prod} + 32)));
endmodule

// File: rtl/dispctl_sync.sv
module dispctl_sync (
  input  logic clk,
  input  logic rst,
  input  logic wr_sync,
  input  logic eng_idle,
  output logic drain_req,
  output logic busy_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drain_req <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      drain_req <= wr_sync;
      if (wr_sync)       busy_q <= 1'b1;
      else if (eng_idle) busy_q <= 1'b0;
    end
  end

  p_busy_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(wr_sync));

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !eng_idle && !wr_sync) |=> busy_q);

  p_drain_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    drain_req |-> busy_q);
endmodule

// File: rtl/dispctl_regport.sv
module dispctl_regport
  import dispctl_pkg::*;
#(
  parameter logic [31:0] ID_BASE  = 32'h5A00_0000,
  parameter int          ID_COUNT = 3,
  parameter logic [31:0] CAPS     = 32'h0000_0002,
  parameter int          EMU_BIT  = 1,
  parameter int          HOST_BPP = 32,
  parameter int          MAX_W    = 2048,
  parameter int          MAX_H    = 1536,
  parameter int          RST_W    = 640,
  parameter int          RST_H    = 480,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1),
  localparam int PW = WW + 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic          io_sel,
  input  logic [31:0]   io_wdata,
  output logic [31:0]   io_rdata,
  output logic          io_rvalid,
  input  logic          eng_idle,
  output logic          disp_on,
  output logic          fetch_en,
  output logic          drain_req,
  output logic          busy,
  output logic [WW-1:0] mode_width,
  output logic [HW-1:0] mode_height,
  output logic [BPP_W-1:0] mode_bpp,
  output logic [PW-1:0] line_pitch
);
  localparam bit EMU_ON = CAPS[EMU_BIT];

  logic [31:0] idx_q;
  logic        val_wr;
  logic [31:0] id_q;
  logic [31:0] rd_mux;

  assign val_wr = io_wr && (io_sel == SEL_VALUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      disp_on  <= 1'b0;
      fetch_en <= 1'b0;
    end else begin
      if (io_wr && io_sel == SEL_INDEX)  idx_q    <= io_wdata;
      if (val_wr && idx_q == IX_ENABLE)   disp_on  <= io_wdata[0];
      if (val_wr && idx_q == IX_CFG_DONE) fetch_en <= io_wdata[0];
    end
  end

  dispctl_version #(.ID_BASE(ID_BASE), .ID_COUNT(ID_COUNT)) u_version (
    .clk(clk), .rst(rst),
    .wr_en(val_wr && idx_q == IX_ID), .wr_val(io_wdata), .id_q(id_q)
  );

  dispctl_mode #(
    .MAX_W(MAX_W), .MAX_H(MAX_H), .RST_W(RST_W), .RST_H(RST_H),
    .HOST_BPP(HOST_BPP), .EMU_ON(EMU_ON)
  ) u_mode (
    .clk(clk), .rst(rst),
    .wr_w(val_wr && idx_q == IX_WIDTH),
    .wr_h(val_wr && idx_q == IX_HEIGHT),
    .wr_b(val_wr && idx_q == IX_BPP),
    .wr_val(io_wdata),
    .w_q(mode_width), .h_q(mode_height), .b_q(mode_bpp), .pitch_q(line_pitch)
  );

  dispctl_sync u_sync (
    .clk(clk), .rst(rst),
    .wr_sync(val_wr && idx_q == IX_SYNC), .eng_idle(eng_idle),
    .drain_req(drain_req), .busy_q(busy)
  );

  always_comb begin
    rd_mux = '0;
    case (idx_q)
      IX_ID:       rd_mux = id_q;
      IX_ENABLE:   rd_mux = {31'd0, disp_on};
      IX_WIDTH:    rd_mux = 32'(mode_width);
      IX_HEIGHT:   rd_mux = 32'(mode_height);
      IX_MAX_W:    rd_mux = 32'(MAX_W);
      IX_MAX_H:    rd_mux = 32'(MAX_H);
      IX_BPP:      rd_mux = 32'(mode_bpp);
      IX_HOST_BPP: rd_mux = 32'(HOST_BPP);
      IX_PITCH:    rd_mux = 32'(line_pitch);
      IX_CAPS:     rd_mux = CAPS;
      IX_CFG_DONE: rd_mux = {31'd0, fetch_en};
      IX_BUSY:     rd_mux = {31'd0, busy};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata  <= '0;
      io_rvalid <= 1'b0;
    end else begin
      io_rvalid <= io_rd;
      if (io_rd) io_rdata <= (io_sel == SEL_INDEX) ? idx_q : rd_mux;
    end
  end

  p_rvalid_r1: assert property (@(posedge clk) disable iff (rst)
    io_rvalid |-> $past(io_rd));

  p_enable_r5: assert property (@(posedge clk) disable iff (rst)
    (val_wr && idx_q == IX_ENABLE) |=> (disp_on == $past(io_wdata[0])));

  p_fetch_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(val_wr && idx_q == IX_CFG_DONE) |=> $stable(fetch_en));
endmodule

// File: tb/test_dispctl_regport.sv
module test_dispctl_regport;
  localparam logic [31:0] IDB = 32'h5A00_0000;
  localparam int HBPP = 24;
  localparam int MW = 1280;
  localparam int MH = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_wr = 1'b0, io_rd = 1'b0, io_sel = 1'b0, eng_idle = 1'b1;
  logic [31:0] io_wdata = '0;
  logic [31:0] rdata, rdata2;
  logic rvalid, rvalid2;
  logic disp_on, fetch_en, drain_req, busy;
  logic [10:0] mw;
  logic [10:0] mh;
  logic [5:0] mb;
  logic [14:0] mp;
  logic disp_on2, fetch_en2, drain_req2, busy2;
  logic [10:0] mw2;
  logic [10:0] mh2;
  logic [5:0] mb2;
  logic [14:0] mp2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dispctl_regport #(.ID_BASE(IDB), .ID_COUNT(3), .CAPS(32'h2), .EMU_BIT(1),
    .HOST_BPP(HBPP), .MAX_W(MW), .MAX_H(MH)) i_dispctl_regport (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
    .io_wdata(io_wdata), .io_rdata(rdata), .io_rvalid(rvalid), .eng_idle(eng_idle),
    .disp_on(disp_on), .fetch_en(fetch_en), .drain_req(drain_req), .busy(busy),
    .mode_width(mw), .mode_height(mh), .mode_bpp(mb), .line_pitch(mp));

  dispctl_regport #(.ID_BASE(IDB), .ID_COUNT(3), .CAPS(32'h0), .EMU_BIT(1),
    .HOST_BPP(HBPP), .MAX_W(MW), .MAX_H(MH)) i_dispctl_regport_noemu (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
    .io_wdata(io_wdata), .io_rdata(rdata2), .io_rvalid(rvalid2), .eng_idle(eng_idle),
    .disp_on(disp_on2), .fetch_en(fetch_en2), .drain_req(drain_req2), .busy(busy2),
    .mode_width(mw2), .mode_height(mh2), .mode_bpp(mb2), .line_pitch(mp2));

  function automatic int exp_pitch(int w, int b);
    int bits = w * b;
    int words = bits / 32;
    if (bits % 32 != 0) words = words + 1;
    return words * 4;
  endfunction

  function automatic logic [31:0] exp_id(logic [31:0] v);
    if (v > IDB + 2) return IDB + 2;
    if (v < IDB) return IDB;
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic sel, logic [31:0] d);
    @(negedge clk);
    io_sel = sel; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(logic sel, output logic [31:0] d, output logic [31:0] d2, output logic v);
    @(negedge clk);
    io_sel = sel; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = rdata; d2 = rdata2; v = rvalid;
  endtask

  task automatic reg_wr(logic [31:0] ix, logic [31:0] d);
    bus_wr(1'b0, ix);
    bus_wr(1'b1, d);
  endtask

  task automatic reg_rd(logic [31:0] ix, output logic [31:0] d, output logic [31:0] d2);
    logic v;
    bus_wr(1'b0, ix);
    bus_rd(1'b1, d, d2, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic v;
    int ew, eh, eb;
    int seed;
    seed = 7;
    void'($urandom(seed));
    ew = 640; eh = 480; eb = HBPP;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 disp_on", 32'(disp_on), 0);
    chk("R11 fetch_en", 32'(fetch_en), 0);
    chk("R11 busy", 32'(busy), 0);
    chk("R11 width", 32'(mw), 640);
    chk("R11 height", 32'(mh), 480);
    chk("R11 bpp", 32'(mb), HBPP);
    bus_rd(1'b0, d, d2, v);
    chk("R11 index", d, 0);
    chk("R1 rvalid", 32'(v), 1);
    @(negedge clk);
    chk("R1 rvalid drop", 32'(rvalid), 0);

    // R1 index readback
    bus_wr(1'b0, 32'hDEAD_0005);
    bus_rd(1'b0, d, d2, v);
    chk("R1 index readback", d, 32'hDEAD_0005);

    // R2 version handshake
    reg_rd(0, d, d2);
    chk("R2 reset id", d, IDB + 2);
    begin
      logic [31:0] tries [6];
      tries = '{IDB + 9, IDB + 2, IDB + 1, IDB, IDB - 1, 32'hFFFF_FFFF};
      foreach (tries[k]) begin
        reg_wr(0, tries[k]);
        reg_rd(0, d, d2);
        chk("R2 id", d, exp_id(tries[k]));
      end
    end
    // R2 step-down loop converges
    begin
      logic [31:0] want = IDB + 40;
      int steps = 0;
      forever begin
        reg_wr(0, want);
        reg_rd(0, d, d2);
        if (d == want || steps > 60) break;
        want = want - 1;
        steps++;
      end
      chk("R2 converge", want, IDB + 2);
    end

    // R5 enable
    reg_wr(1, 32'h1);
    chk("R5 disp_on set", 32'(disp_on), 1);
    reg_rd(1, d, d2);
    chk("R5 enable read", d, 1);
    reg_wr(1, 32'h2);
    chk("R5 disp_on clear", 32'(disp_on), 0);

    // R6 config done
    reg_wr(10, 32'h1);
    chk("R6 fetch_en set", 32'(fetch_en), 1);
    reg_wr(10, 32'h0);
    chk("R6 fetch_en clear", 32'(fetch_en), 0);

    // R3 / R4 bpp filtering
    reg_wr(6, 8);
    reg_rd(6, d, d2);
    chk("R4 bpp 8 accepted", d, 8); eb = 8;
    chk("R3 bpp read-only", d2, HBPP);
    reg_wr(6, 16);
    reg_rd(6, d, d2);
    chk("R4 bpp 16 ignored", d, 8);
    chk("R3 bpp read-only 16", d2, HBPP);
    reg_wr(6, HBPP);
    reg_rd(6, d, d2);
    chk("R4 bpp host accepted", d, HBPP); eb = HBPP;

    // R8 pitch directed
    reg_wr(2, 5);
    reg_rd(8, d, d2);
    chk("R8 pitch w5", d, exp_pitch(5, HBPP)); ew = 5;

    // R9 limits
    reg_wr(2, MW);
    reg_rd(2, d, d2);
    chk("R9 width at max", d, MW); ew = MW;
    reg_wr(2, MW + 1);
    reg_rd(2, d, d2);
    chk("R9 width over max", d, MW);
    reg_wr(3, MH + 1);
    reg_rd(3, d, d2);
    chk("R9 height over max", d, eh);
    reg_rd(4, d, d2);
    chk("R9 max width reg", d, MW);

    // R10 read-only and unimplemented
    reg_wr(8, 32'h1234);
    reg_rd(8, d, d2);
    chk("R10 pitch read-only", d, exp_pitch(ew, eb));
    reg_wr(9, 32'hFFFF);
    reg_rd(9, d, d2);
    chk("R10 caps read-only", d, 32'h2);
    reg_wr(7, 8);
    reg_rd(7, d, d2);
    chk("R10 host bpp read-only", d, HBPP);
    reg_wr(13, 32'hFFFF_FFFF);
    reg_rd(13, d, d2);
    chk("R10 unimpl read", d, 0);
    reg_wr(32'h100, 32'h1);
    chk("R10 unimpl write disp_on", 32'(disp_on), 0);
    reg_rd(0, d, d2);
    chk("R10 unimpl write id", d, IDB + 2);
    reg_rd(2, d, d2);
    chk("R10 unimpl write width", d, ew);

    // R7 sync / busy
    eng_idle = 1'b0;
    bus_wr(1'b0, 11);
    @(negedge clk);
    io_sel = 1'b1; io_wdata = 0; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    chk("R7 drain_req", 32'(drain_req), 1);
    chk("R7 busy set", 32'(busy), 1);
    @(negedge clk);
    chk("R7 drain_req pulse", 32'(drain_req), 0);
    reg_rd(12, d, d2);
    chk("R7 busy read", d, 1);
    eng_idle = 1'b1;
    @(negedge clk);
    chk("R7 busy clear", 32'(busy), 0);
    reg_rd(12, d, d2);
    chk("R7 busy read clear", d, 0);

    // random width/height/bpp with pitch model (R8, R9, R4)
    for (int i = 0; i < 150; i++) begin
      int sel = $urandom % 3;
      int val;
      if (sel == 0) begin
        val = $urandom % (MW + 200);
        reg_wr(2, val);
        if (val <= MW) ew = val;
      end else if (sel == 1) begin
        val = $urandom % (MH + 200);
        reg_wr(3, val);
        if (val <= MH) eh = val;
      end else begin
        case ($urandom % 4)
          0: val = 8;
          1: val = 16;
          2: val = 24;
          default: val = 32;
        endcase
        reg_wr(6, val);
        if (val == 8 || val == HBPP) eb = val;
      end
      reg_rd(8, d, d2);
      chk("R8 random pitch", d, exp_pitch(ew, eb));
      reg_rd(2, d, d2);
      chk("R9 random width", d, ew);
      reg_rd(3, d, d2);
      chk("R9 random height", d, eh);
      reg_rd(6, d, d2);
      chk("R4 random bpp", d, eb);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule